// File: doc/BRIEF.md
# Brown-out Reset Release Sequencer

This block turns the output of a supply brown-out comparator into a device reset. It also decides when that reset may be lifted again. A brown-out asserts the reset at once, with no clock involved. Release is synchronous and waits until every readiness condition that applies to the configured clock source has been met:

- the oscillator start-up count, when the source is a crystal;
- PLL lock, when the source runs through the PLL;
- the power-up delay, which always applies.

These waits run side by side, so the total delay is set by the slowest of them, not by their sum. A crystal source with a zero power-up setting gets a fixed fail-safe delay in place of the power-up delay.

While the sequence runs, the block holds the system clock off until the oscillator count has finished and the PLL (if used) has locked. It also raises an enable for the oscillator start-up timer during that count. A sticky flag records that a brown-out caused the reset, and software clears it with a one-cycle pulse. The configuration is captured once, when the sequence starts counting.

Top module: `bor_release_seq`

## Requirements
- R1: While `bor_det_i` is high, `dev_rst_o` and `clk_hold_o` are high in the same cycle, without waiting for a clock edge.
- R2: `bor_det_i` passes through a two-flop synchronizer before the sequence starts. With no gate pending, `dev_rst_o` falls after the 4th rising edge that follows the fall of `bor_det_i`. In general it falls after edge T+4, where T is the longest active count.
- R3: The source code `osc_sel_i` is decoded as follows:
  - 0, 5, 6 and 7 are internal sources with no oscillator wait and no PLL;
  - 1 is internal with PLL;
  - 2 is the primary source;
  - 3 is the primary source with PLL;
  - 4 is a secondary crystal, which always needs the oscillator wait.
  The primary source is a crystal only when `pri_mode_i` is 1 or 2; with 0 (external clock) or 3 it has no oscillator wait.
- R4: For a crystal source, `ost_en_o` and `clk_hold_o` stay high from the start of counting until OST_CYCLES clock cycles have elapsed. `ost_en_o` is never high while `dev_rst_o` is low.
- R5: For a PLL source, `dev_rst_o` and `clk_hold_o` stay high until `pll_lock_i` is sampled high. Release then comes on the following edge if the other gates are done.
- R6: The power-up count of `pwrt_dly_i` cycles runs at the same time as the oscillator count. The release delay is the larger of the two, not their sum.
- R7: When `pwrt_dly_i` is zero and the source is a crystal, the power-up count is FSCM_CYCLES. A non-zero `pwrt_dly_i` is used as given.
- R8: `bor_stat_o` is 0 after `rst_n`. It is set on the edge after a synchronized brown-out and stays set until a `stat_clr_i` pulse. A brown-out in the same cycle as a clear leaves it set.
- R9: `sleep_i` and `idle_i` have no effect: a brown-out in either mode still resets the device, and release timing is unchanged.
- R10: A brown-out during the wait restarts the sequence; timing is then measured from the new fall of `bor_det_i`.
- R11: Source code and power-up setting are captured when counting starts; changes during the wait do not alter the release time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| bor_det_i | input | 1 | Asynchronous brown-out comparator output, high = supply low |
| osc_sel_i | input | 3 | Clock source select code |
| pri_mode_i | input | 2 | Primary oscillator mode code |
| pll_lock_i | input | 1 | PLL lock indication |
| pwrt_dly_i | input | PWRT_W | Power-up delay in clock cycles |
| sleep_i | input | 1 | Sleep mode flag |
| idle_i | input | 1 | Idle mode flag |
| stat_clr_i | input | 1 | Software clear of the brown-out flag |
| dev_rst_o | output | 1 | Device reset, active high |
| clk_hold_o | output | 1 | Hold request for the system clock |
| ost_en_o | output | 1 | Oscillator start-up timer enable |
| bor_stat_o | output | 1 | Sticky brown-out cause flag |

## Verification
The bench measures the release latency edge by edge for every source class. A design that summed the oscillator and power-up counts, or skipped the fail-safe substitution, would release late or early by tens of cycles. It raises a second brown-out in the middle of a wait and changes the configuration during counting. A sequencer that failed to restart, or that read live configuration, would release too soon. It also probes the oscillator enable and clock hold partway through the waits. It drives a brown-out into the flag together with a software clear, which a clear-priority flag would lose.

// File: rtl/bor_pkg.sv
package bor_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HOLD = 2'd1,
      ST_WAIT = 2'd2
   } seq_st_e;

   typedef struct packed {
      logic ost;   // oscillator start-up wait needed
      logic pll;   // PLL lock needed
      logic xtal;  // crystal in use
   } clk_src_t;

   function automatic clk_src_t decode_src(input logic [2:0] sel, input logic [1:0] pmode);
      clk_src_t s;
      logic     pri_xtal;
      pri_xtal = (pmode == 2'd1) || (pmode == 2'd2);
      s = '0;
      unique case (sel)
         3'd1: s.pll = 1'b1;
         3'd2: begin
            s.ost  = pri_xtal;
            s.xtal = pri_xtal;
         end
         3'd3: begin
            s.ost  = pri_xtal;
            s.xtal = pri_xtal;
            s.pll  = 1'b1;
         end
         3'd4: begin
            s.ost  = 1'b1;
            s.xtal = 1'b1;
         end
         default: s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bor_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] q;

   // assertion reaches the output at once; release walks through the chain
   always_ff @(posedge clk or posedge async_i or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (async_i)
         q <= '1;
      else
         q <= {q[STAGES-2:0], 1'b0};
   end

   assign sync_o = q[STAGES-1];

   AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      async_i |=> sync_o)  // R2
      else $error("AST_SYNC_HOLD");

endmodule

// File: rtl/bor_gate_cnt.sv
module bor_gate_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] target,
   output logic         done
);

   generate
      if (W < 1) begin : g_bad_w
         $error("bor_gate_cnt: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (cnt != target)
         cnt <= cnt + W'(1);
   end

   assign done = (cnt == target);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt <= target))  // R6
      else $error("AST_CNT_BOUND");

endmodule

// File: rtl/bor_release_seq.sv
module bor_release_seq
   import bor_pkg::*;
#(
   parameter int OST_CYCLES  = 1024,
   parameter int FSCM_CYCLES = 100,
   parameter int PWRT_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bor_det_i,
   input  logic [2:0]        osc_sel_i,
   input  logic [1:0]        pri_mode_i,
   input  logic              pll_lock_i,
   input  logic [PWRT_W-1:0] pwrt_dly_i,
   input  logic              sleep_i,
   input  logic              idle_i,
   input  logic              stat_clr_i,
   output logic              dev_rst_o,
   output logic              clk_hold_o,
   output logic              ost_en_o,
   output logic              bor_stat_o
);

   localparam int OST_W = $clog2(OST_CYCLES + 1);
   localparam int FS_W  = (FSCM_CYCLES > 0) ? $clog2(FSCM_CYCLES + 1) : 1;
   localparam int PWR_W = (PWRT_W > FS_W) ? PWRT_W : FS_W;

   generate
      if (OST_CYCLES < 1) begin : g_bad_ost
         $error("bor_release_seq: OST_CYCLES must be at least 1");
      end
      if (PWRT_W < 1) begin : g_bad_pwrt
         $error("bor_release_seq: PWRT_W must be at least 1");
      end
      if (FSCM_CYCLES < 0) begin : g_bad_fscm
         $error("bor_release_seq: FSCM_CYCLES must not be negative");
      end
   endgenerate

   // ---------------- brown-out synchronizer ----------------
   logic bor_sync;

   bor_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (bor_det_i),
      .sync_o  (bor_sync)
   );

   // ---------------- configuration capture ----------------
   clk_src_t   src_now, src_q;
   logic [PWR_W-1:0] pwr_now, pwr_tgt_q;
   logic [OST_W-1:0] ost_tgt_q;

   assign src_now = decode_src(osc_sel_i, pri_mode_i);

   generate
      if (FSCM_CYCLES > 0) begin : g_fscm
         assign pwr_now = ((pwrt_dly_i == '0) && src_now.xtal) ?
                          PWR_W'(FSCM_CYCLES) : PWR_W'(pwrt_dly_i);
      end else begin : g_no_fscm
         assign pwr_now = PWR_W'(pwrt_dly_i);
      end
   endgenerate

   // ---------------- sequence state ----------------
   seq_st_e st, st_nx;
   logic    ost_done, pwr_done, pll_ok, cnt_clr;

   assign pll_ok  = !src_q.pll || pll_lock_i;
   assign cnt_clr = (st != ST_WAIT);

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_RUN:  if (bor_sync) st_nx = ST_HOLD;
         ST_HOLD: if (!bor_sync) st_nx = ST_WAIT;
         ST_WAIT: begin
            if (bor_sync)
               st_nx = ST_HOLD;
            else if (ost_done && pwr_done && pll_ok)
               st_nx = ST_RUN;
         end
         default: st_nx = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_RUN;
         src_q     <= '0;
         ost_tgt_q <= '0;
         pwr_tgt_q <= '0;
      end else begin
         st <= st_nx;
         if (st == ST_HOLD && !bor_sync) begin
            src_q     <= src_now;
            ost_tgt_q <= src_now.ost ? OST_W'(OST_CYCLES) : '0;
            pwr_tgt_q <= pwr_now;
         end
      end
   end

   // ---------------- concurrent gate counters ----------------
   bor_gate_cnt #(.W(OST_W)) u_ost_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_clr),
      .target (ost_tgt_q),
      .done   (ost_done)
   );

   bor_gate_cnt #(.W(PWR_W)) u_pwr_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_clr),
      .target (pwr_tgt_q),
      .done   (pwr_done)
   );

   // ---------------- outputs ----------------
   assign dev_rst_o  = bor_det_i || (st != ST_RUN);
   assign clk_hold_o = bor_det_i || (st == ST_HOLD) ||
                       ((st == ST_WAIT) && (!ost_done || !pll_ok));
   assign ost_en_o   = (st == ST_WAIT) && !ost_done;

   // ---------------- sticky cause flag ----------------
   logic stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= 1'b0;
      else if (bor_sync)
         stat_q <= 1'b1;
      else if (stat_clr_i)
         stat_q <= 1'b0;
   end

   assign bor_stat_o = stat_q;

   // ---------------- assertions ----------------
   AST_BOR_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
      bor_sync |=> (dev_rst_o && clk_hold_o))  // R1
      else $error("AST_BOR_HOLDS_RST");

   AST_OST_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      ost_en_o |-> dev_rst_o)  // R4
      else $error("AST_OST_IN_RST");

   AST_PLL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && src_q.pll && !pll_lock_i) |=> dev_rst_o)  // R5
      else $error("AST_PLL_GATE");

   AST_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !(ost_done && pwr_done)) |=> dev_rst_o)  // R6
      else $error("AST_NOT_READY");

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      bor_sync |=> bor_stat_o)  // R8
      else $error("AST_FLAG_SET");

   AST_LOWPWR_MON: assert property (@(posedge clk) disable iff (!rst_n)
      ((sleep_i || idle_i) && bor_sync) |=> (st == ST_HOLD))  // R9
      else $error("AST_LOWPWR_MON");

   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && bor_sync) |=> (st == ST_HOLD))  // R10
      else $error("AST_RESTART");

   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && $past(st) == ST_WAIT) |-> ($stable(pwr_tgt_q) && $stable(src_q)))  // R11
      else $error("AST_CFG_STABLE");

endmodule

// File: tb/bor_release_seq_test.sv
module bor_release_seq_test;

   localparam int OST  = 64;
   localparam int FSCM = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bor = 1'b0;
   logic [2:0] sel = 3'd0;
   logic [1:0] pm = 2'd0;
   logic       lock = 1'b1;
   logic [7:0] pwrt = 8'd0;
   logic       sleep = 1'b0;
   logic       idle = 1'b0;
   logic       clr = 1'b0;
   logic       dev_rst, clk_hold, ost_en, stat;

   int checks = 0;
   int fails = 0;
   int edge_cnt = 0;
   logic prev_rst = 1'b0;
   int exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   bor_release_seq #(.OST_CYCLES(OST), .FSCM_CYCLES(FSCM), .PWRT_W(8), .SYNC_STAGES(2)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bor_det_i  (bor),
      .osc_sel_i  (sel),
      .pri_mode_i (pm),
      .pll_lock_i (lock),
      .pwrt_dly_i (pwrt),
      .sleep_i    (sleep),
      .idle_i     (idle),
      .stat_clr_i (clr),
      .dev_rst_o  (dev_rst),
      .clk_hold_o (clk_hold),
      .ost_en_o   (ost_en),
      .bor_stat_o (stat)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: measures release latency and pops the scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1;
         edge_cnt++;
         if (prev_rst && !dev_rst) begin
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL unexpected release: actual=%0d expected=none", edge_cnt);
            end else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (edge_cnt != e) begin
                  fails++;
                  $display("FAIL %s latency: actual=%0d expected=%0d", t, edge_cnt, e);
               end
            end
         end
         prev_rst = dev_rst;
      end
   end

   task automatic wait_release();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!dev_rst) break;
      end
      repeat (2) @(negedge clk);
   endtask

   // driver: pushes the expected latency, runs one brown-out sequence
   // probe: 0 none, 1 oscillator wait, 2 PLL wait
   task automatic run_case(input logic [2:0] s, input logic [1:0] p, input logic [7:0] d,
                           input int lock_dly, input int exp, input int probe, input string tag);
      @(negedge clk);
      sel = s; pm = p; pwrt = d;
      lock = (lock_dly == 0);
      bor = 1'b1;
      #1;
      check("R1 immediate reset", dev_rst, 1'b1);
      check("R1 immediate hold", clk_hold, 1'b1);
      repeat (3) @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bor = 1'b0;
      edge_cnt = 0;
      if (probe == 1) begin
         repeat (20) @(posedge clk);
         #1;
         check("R4 ost_en during count", ost_en, 1'b1);
         check("R4 hold during count", clk_hold, 1'b1);
         repeat (60) @(posedge clk);
         #1;
         check("R4 ost_en after count", ost_en, 1'b0);
         check("R4 hold after count", clk_hold, 1'b0);
         check("R7 reset held by fail-safe", dev_rst, 1'b1);
      end
      if (lock_dly > 0) begin
         repeat (lock_dly - 50) @(posedge clk);
         #1;
         if (probe == 2) begin
            check("R5 hold before lock", clk_hold, 1'b1);
            check("R5 reset before lock", dev_rst, 1'b1);
         end
         repeat (50) @(posedge clk);
         @(negedge clk);
         lock = 1'b1;
      end
      wait_release();
   endtask

   // watchdog
   initial begin
      #500000;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 reset flag", stat, 1'b0);
      check("R2 reset released idle", dev_rst, 1'b0);
      check("R4 reset ost_en", ost_en, 1'b0);

      run_case(3'd0, 2'd0, 8'd0,   0,   4, 0, "R2 no gates");
      check("R8 flag set", stat, 1'b1);
      run_case(3'd0, 2'd0, 8'd50,  0,  54, 0, "R6 power-up only");
      run_case(3'd2, 2'd1, 8'd0,   0, FSCM + 4, 1, "R7 crystal fail-safe");
      run_case(3'd2, 2'd1, 8'd10,  0, OST + 4, 0, "R7 nonzero setting kept");
      run_case(3'd2, 2'd2, 8'd200, 0, 204, 0, "R6 concurrent not summed");
      run_case(3'd2, 2'd0, 8'd0,   0,   4, 0, "R3 external clock");
      run_case(3'd4, 2'd0, 8'd0,   0, FSCM + 4, 0, "R3 secondary crystal");
      run_case(3'd7, 2'd1, 8'd0,   0,   4, 0, "R3 internal ignores mode");
      run_case(3'd1, 2'd0, 8'd0, 150, 151, 2, "R5 PLL lock wait");
      run_case(3'd3, 2'd2, 8'd0,   0, FSCM + 4, 0, "R5 PLL crystal locked");

      // R9: sleep and idle do not block monitoring
      sleep = 1'b1;
      run_case(3'd0, 2'd0, 8'd0,   0,   4, 0, "R9 sleep");
      sleep = 1'b0; idle = 1'b1;
      run_case(3'd0, 2'd0, 8'd30,  0,  34, 0, "R9 idle");
      idle = 1'b0;

      // R10: brown-out in the middle of the wait restarts the sequence
      @(negedge clk);
      sel = 3'd0; pwrt = 8'd50; bor = 1'b1;
      repeat (3) @(negedge clk);
      bor = 1'b0;
      edge_cnt = 0;
      repeat (30) @(posedge clk);
      @(negedge clk);
      bor = 1'b1;
      #1;
      check("R10 reasserted reset", dev_rst, 1'b1);
      @(negedge clk);
      exp_q.push_back(54);
      tag_q.push_back("R10 restart");
      bor = 1'b0;
      edge_cnt = 0;
      wait_release();

      // R11: configuration changes during the wait are ignored
      @(negedge clk);
      sel = 3'd0; pwrt = 8'd50; bor = 1'b1;
      repeat (3) @(negedge clk);
      exp_q.push_back(54);
      tag_q.push_back("R11 captured config");
      bor = 1'b0;
      edge_cnt = 0;
      repeat (10) @(posedge clk);
      @(negedge clk);
      pwrt = 8'd0; sel = 3'd2; pm = 2'd0;
      wait_release();

      // R8: software clear, then clear colliding with a brown-out
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check("R8 flag cleared", stat, 1'b0);
      sel = 3'd0; pwrt = 8'd0;
      bor = 1'b1; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check("R8 set wins over clear", stat, 1'b1);
      @(negedge clk);
      exp_q.push_back(4);
      tag_q.push_back("R8 collision release");
      bor = 1'b0;
      edge_cnt = 0;
      wait_release();
      check("R8 flag still set", stat, 1'b1);

      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule